// File: doc/BRIEF.md
# Multi-Phase Cycle Slip Detector

This block watches two pulse trains from the tap edges of two ring oscillators, A and B, and reports when their phase difference leaves a window. Each oscillator provides a bank of single-cycle pulse lines, one per tap edge. All lines are sampled on a fast system clock. If one oscillator produces two events while the other produces none, the phase has slipped by more than one tap spacing. With twelve taps per oscillator, that window is a single tap spacing. With two taps, it is half an oscillator period.

The tap lines of each oscillator are first merged into one event stream. Two mirrored counting chains then follow the two streams. One chain counts A events since the latest B event and flags a lead. The other counts B events since the latest A event and flags a lag. A lead or lag detection produces a one-cycle pulse, which a divider can take as an injected count. The block also keeps a held direction level for clamping. That level changes only when the opposite slip is detected.

Top module: `cycle_slip_detector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four outputs are low.
- R2: An oscillator has an event in a cycle when at least one of its N tap lines is high in that cycle. Several lines high in the same cycle count as a single event.
- R3: After a B event, a second A event with no B event in between drives `lead_pulse` high. It goes high for exactly one cycle, right after the clock edge that samples that second A event.
- R4: After an A event, a second B event with no A event in between drives `lag_pulse` high. The timing matches R3.
- R5: A events that come before the first B event since reset never produce a lead. B events that come before the first A event never produce a lag.
- R6: When an A event and a B event arrive in the same cycle, both counts clear and both chains are armed. Neither pulse is raised for that cycle.
- R7: After a detection, the count of that chain restarts from zero. Two more events of the same oscillator with no opposite event in between give a further pulse. A single event followed by an opposite event gives none.
- R8: `lead_level` goes high together with `lead_pulse` and holds until a `lag_pulse`. That `lag_pulse` clears it and sets `lag_level`, which is mirrored in the same way. The two levels are never high together.
- R9: `lead_pulse` and `lag_pulse` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_a_taps | input | N_TAPS | Tap-edge pulse lines of oscillator A |
| osc_b_taps | input | N_TAPS | Tap-edge pulse lines of oscillator B |
| lead_pulse | output | 1 | One-cycle pulse when A slips ahead |
| lag_pulse | output | 1 | One-cycle pulse when A slips behind |
| lead_level | output | 1 | Held lead direction |
| lag_level | output | 1 | Held lag direction |

## Verification
On every cycle, the assertions enforce:
- the two pulses are mutually exclusive;
- the two levels are never both high;
- each pulse coincides with its level;
- the levels stay put when no pulse occurs;
- a coincident event pair yields no pulse;
- a chain's count never reaches its threshold.

Other behaviour depends on the history of event order and can be shown only by the bench's scenarios:
- a lead or lag appears on exactly the second unanswered event;
- an unarmed chain stays silent;
- the count restarts after each detection;
- multi-tap cycles count once.

The bench checks these against a reference model under directed sequences and under random streams with equal, faster-A and faster-B rates.

// File: rtl/slipdet_pkg.sv
package slipdet_pkg;

  typedef logic [7:0] hit_cnt_t;

  typedef struct packed {
    logic     armed;
    hit_cnt_t cnt;
    logic     det;
  } chain_next_t;

  // One step of a counting chain: ref events arm and clear, own events count.
  function automatic chain_next_t chain_step(
    input logic     armed,
    input hit_cnt_t cnt,
    input logic     own_ev,
    input logic     ref_ev,
    input hit_cnt_t hits
  );
    chain_next_t nx;
    nx.armed = armed;
    nx.cnt   = cnt;
    nx.det   = 1'b0;
    if (ref_ev) begin
      nx.armed = 1'b1;
      nx.cnt   = '0;
    end else if (own_ev && armed) begin
      if ((cnt + 8'd1) >= hits) begin
        nx.det = 1'b1;
        nx.cnt = '0;
      end else begin
        nx.cnt = cnt + 8'd1;
      end
    end
    return nx;
  endfunction

endpackage

// File: rtl/slip_tap_merge.sv
module slip_tap_merge #(
  parameter int N_TAPS = 12
) (
  input  logic [N_TAPS-1:0] taps,
  output logic              event_o
);
  generate
    if (N_TAPS == 1) begin : g_single
      assign event_o = taps[0];
    end else begin : g_multi
      assign event_o = |taps;
    end
  endgenerate
endmodule

// File: rtl/slip_chain.sv
module slip_chain
  import slipdet_pkg::*;
#(
  parameter int SLIP_HITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic own_ev,
  input  logic ref_ev,
  output logic det_o
);
  localparam hit_cnt_t HITS = hit_cnt_t'(SLIP_HITS);

  logic        armed_q;
  hit_cnt_t    cnt_q;
  chain_next_t nx;

  always_comb nx = chain_step(armed_q, cnt_q, own_ev, ref_ev, HITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= nx.armed;
      cnt_q   <= nx.cnt;
    end
  end

  assign det_o = nx.det;

  // R7
  cnt_below_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < HITS);

  // R5
  unarmed_no_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !det_o);
endmodule

// File: rtl/slip_level.sv
module slip_level (
  input  logic clk,
  input  logic rst_n,
  input  logic set_lead,
  input  logic set_lag,
  output logic lead_lvl,
  output logic lag_lvl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_lvl <= 1'b0;
      lag_lvl  <= 1'b0;
    end else if (set_lead) begin
      lead_lvl <= 1'b1;
      lag_lvl  <= 1'b0;
    end else if (set_lag) begin
      lead_lvl <= 1'b0;
      lag_lvl  <= 1'b1;
    end
  end

  // R8
  level_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_lvl, lag_lvl}));
endmodule

// File: rtl/cycle_slip_detector.sv
module cycle_slip_detector #(
  parameter int N_TAPS    = 12,
  parameter int SLIP_HITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TAPS-1:0] osc_a_taps,
  input  logic [N_TAPS-1:0] osc_b_taps,
  output logic              lead_pulse,
  output logic              lag_pulse,
  output logic              lead_level,
  output logic              lag_level
);
  logic a_ev;
  logic b_ev;
  logic lead_det;
  logic lag_det;

  slip_tap_merge #(.N_TAPS(N_TAPS)) u_merge_a (.taps(osc_a_taps), .event_o(a_ev));
  slip_tap_merge #(.N_TAPS(N_TAPS)) u_merge_b (.taps(osc_b_taps), .event_o(b_ev));

  slip_chain #(.SLIP_HITS(SLIP_HITS)) u_lead_chain (
    .clk(clk), .rst_n(rst_n), .own_ev(a_ev), .ref_ev(b_ev), .det_o(lead_det));

  slip_chain #(.SLIP_HITS(SLIP_HITS)) u_lag_chain (
    .clk(clk), .rst_n(rst_n), .own_ev(b_ev), .ref_ev(a_ev), .det_o(lag_det));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_pulse <= 1'b0;
      lag_pulse  <= 1'b0;
    end else begin
      lead_pulse <= lead_det;
      lag_pulse  <= lag_det;
    end
  end

  slip_level u_level (
    .clk(clk), .rst_n(rst_n), .set_lead(lead_det), .set_lag(lag_det),
    .lead_lvl(lead_level), .lag_lvl(lag_level));

  // R9
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_pulse && lag_pulse));

  // R6
  coincident_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ev && b_ev) |=> (!lead_pulse && !lag_pulse));

  // R8
  lead_pulse_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_pulse |-> lead_level);

  // R8
  lag_pulse_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lag_pulse |-> lag_level);

  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lead_pulse && !lag_pulse) |-> ($stable(lead_level) && $stable(lag_level)));
endmodule

// File: tb/tb_cycle_slip_detector.sv
module tb_cycle_slip_detector;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] a_taps = '0;
  logic [N-1:0] b_taps = '0;
  logic         lead_pulse, lag_pulse, lead_level, lag_level;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_a_since_b = 0;
  int m_b_since_a = 0;
  bit m_seen_b = 0;
  bit m_seen_a = 0;
  bit e_lead_p = 0, e_lag_p = 0, e_lead_l = 0, e_lag_l = 0;

  always #5 clk = ~clk;

  cycle_slip_detector #(.N_TAPS(N), .SLIP_HITS(2)) dut (
    .clk(clk), .rst_n(rst_n), .osc_a_taps(a_taps), .osc_b_taps(b_taps),
    .lead_pulse(lead_pulse), .lag_pulse(lag_pulse),
    .lead_level(lead_level), .lag_level(lag_level));

  function automatic bit any_hi(input logic [N-1:0] v);
    return v != '0;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model(input bit ae, input bit be);
    e_lead_p = 0;
    e_lag_p  = 0;
    if (ae && be) begin
      m_a_since_b = 0; m_b_since_a = 0; m_seen_a = 1; m_seen_b = 1;
    end else if (ae) begin
      m_seen_a = 1;
      m_b_since_a = 0;
      if (m_seen_b) begin
        m_a_since_b++;
        if (m_a_since_b == 2) begin e_lead_p = 1; m_a_since_b = 0; end
      end
    end else if (be) begin
      m_seen_b = 1;
      m_a_since_b = 0;
      if (m_seen_a) begin
        m_b_since_a++;
        if (m_b_since_a == 2) begin e_lag_p = 1; m_b_since_a = 0; end
      end
    end
    if (e_lead_p) begin e_lead_l = 1; e_lag_l = 0; end
    else if (e_lag_p) begin e_lag_l = 1; e_lead_l = 0; end
  endtask

  // drive at negedge, compare just after the next posedge
  task automatic step(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    a_taps = a;
    b_taps = b;
    model(any_hi(a), any_hi(b));
    @(posedge clk);
    #1;
    chk("R3 lead_pulse", lead_pulse, e_lead_p);
    chk("R4 lag_pulse", lag_pulse, e_lag_p);
    chk("R8 lead_level", lead_level, e_lead_l);
    chk("R8 lag_level", lag_level, e_lag_l);
  endtask

  function automatic logic [N-1:0] rnd_taps(input int pct);
    logic [N-1:0] v;
    logic [31:0] r;
    r = $urandom;
    v = r[N-1:0];
    if (v == '0) v = 1;
    if (($urandom % 100) >= pct) v = '0;
    return v;
  endfunction

  task automatic random_phase(input int pa, input int pb, input int cycles);
    for (int i = 0; i < cycles; i++) step(rnd_taps(pa), rnd_taps(pb));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 lead_pulse", lead_pulse, 1'b0);
    chk("R1 lag_pulse", lag_pulse, 1'b0);
    chk("R1 lead_level", lead_level, 1'b0);
    chk("R1 lag_level", lag_level, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 first cycle lead_level", lead_level, 1'b0);

    // R5: A events before any B event never give a lead
    step(12'h001, '0);
    step(12'h002, '0);
    step(12'h004, '0);
    chk("R5 no lead unarmed", lead_level, 1'b0);

    // R3 and R2: B arms, then two multi-tap A events -> one lead pulse
    step('0, 12'h010);
    step(12'hFFF, '0);
    step(12'h0A5, '0);
    chk("R3 R2 lead after two A", lead_level, 1'b1);

    // R7: one more A then B -> nothing; then two more A -> another pulse
    step(12'h800, '0);
    step('0, 12'h001);
    step(12'h001, '0);
    step(12'h001, '0);
    chk("R7 restart lead", lead_pulse, 1'b1);

    // R6: coincident events clear both counts, no pulse
    step(12'h001, '0);
    step(12'h002, 12'h004);
    chk("R6 coincident quiet", lead_pulse | lag_pulse, 1'b0);
    step(12'h001, '0);
    step('0, '0);
    step(12'h001, '0);
    chk("R6 armed by coincident", lead_pulse, 1'b1);

    // R4 and R8: two B after A -> lag pulse, levels swap
    step(12'h040, '0);
    step('0, 12'h100);
    step('0, 12'h3C0);
    chk("R4 lag pulse", lag_pulse, 1'b1);
    chk("R8 lead cleared by lag", lead_level, 1'b0);

    // R9 plus all: random rate phases
    random_phase(30, 30, 3000);
    random_phase(45, 20, 3000);
    random_phase(20, 45, 3000);
    random_phase(60, 60, 1000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule